// File: doc/BRIEF.md
# Tearing-Sync Frame Transfer Trigger

This block decides the moment at which a block transfer of pixels to an external display controller may begin. When the panel reports its refresh position through tearing-effect sync pulses, the block measures every pulse and classifies it as a line sync or a frame sync. It counts lines from the most recent frame sync and issues a start when a programmed line is reached. This lets the host write the frame memory behind the panel's scan position without visible tearing.

The panel may report sync on one shared pin or on two separate pins. With one shared pin, line and frame sync are told apart only by their measured width. With tearing sync switched off, the host starts the transfer directly with a one-shot request. In every mode, once a transfer has started, the block counts accepted pixels up to a programmed total, raises a completion pulse, and drops busy.

Top module: `te_xfer_trigger`

## Requirements
- R1: After reset, `xfer_start`, `xfer_busy`, `xfer_done` and `start_pending` are all 0.
- R2: With `sync_mode` = 0 (internal trigger) and `enable` high, a `start_req` pulse sets `start_pending` at the next edge. On the following edge `xfer_start` pulses for one cycle and `start_pending` clears at that same edge.
- R3: Each sync pin has its own polarity bit (`pol_a` for `te_a`, `pol_b` for `te_b`). A value of 1 means active-high and 0 means active-low. Pulse width is the number of clock edges at which the synchronized pin is at its active level.
- R4: With `sync_mode` = 1 (one pin), only `te_a` is used and `te_b` has no effect. A completed pulse is first compared against the larger of `hs_min` and `vs_min`, and is classified as the sync that owns that threshold if it reaches it. Otherwise it is classified as the other sync if it reaches the smaller threshold. A pulse shorter than both is ignored.
- R5: With `sync_mode` = 2 (two pins), `te_a` carries line sync and is qualified against `hs_min` only, and `te_b` carries frame sync and is qualified against `vs_min` only. Shorter pulses are ignored.
- R6: A frame sync resets the line count to 0, and each line sync after it advances the count. The start fires on the line sync at which the count equals `trig_line`, which is the (`trig_line`+1)-th line sync after the frame sync. Line syncs seen before the first frame sync of an enable session never fire.
- R7: `xfer_busy` rises together with `xfer_start`. Each edge with `xfer_busy` and `pix_advance` both high counts one pixel. When the count reaches `pix_total`, `xfer_done` pulses for one cycle and `xfer_busy` falls at the same edge.
- R8: At most one `xfer_start` is issued per enable session. Later sync pulses or requests have no effect until `enable` has been low.
- R9: Driving `enable` low clears `xfer_busy` and `start_pending` at the next edge, and no `xfer_done` is produced for the aborted transfer.
- R10: In the tearing-sync modes (`sync_mode` 1 or 2), `start_req` is ignored: `start_pending` stays 0 and no start results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Session enable; low aborts and re-arms |
| sync_mode | input | 2 | 0 internal trigger, 1 one-pin sync, 2 two-pin sync |
| start_req | input | 1 | One-cycle host start request (internal mode) |
| pol_a | input | 1 | Polarity of te_a, 1 = active-high |
| pol_b | input | 1 | Polarity of te_b, 1 = active-high |
| hs_min | input | WIDTH_W | Minimum line-sync width in clock ticks |
| vs_min | input | WIDTH_W | Minimum frame-sync width in clock ticks |
| trig_line | input | LINE_W | Line number on which the start fires |
| pix_total | input | PIX_W | Number of pixels in the transfer |
| te_a | input | 1 | Shared sync pin, or line-sync pin in two-pin mode |
| te_b | input | 1 | Frame-sync pin in two-pin mode |
| pix_advance | input | 1 | One pixel accepted by the downstream path |
| xfer_start | output | 1 | One-cycle transfer start pulse |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle completion pulse |
| start_pending | output | 1 | Internal start requested but not yet begun |

## Verification
The assertions assume that `sync_mode` is never 3 and that the mode, polarity and threshold inputs are held steady for the whole time `enable` is high. In one-pin mode they also assume `hs_min` differs from `vs_min`, with `hs_min` at least 2 and `vs_min` at least 4 (at least 2 in two-pin mode). The stimulus changes configuration only while `enable` is low. It then leaves several idle cycles so that the synchronizers settle to the inactive level before a session opens. It separates sync pulses by a gap longer than the trigger latency, so that each start can be tied to the line sync that caused it.

// File: rtl/te_trig_pkg.sv
package te_trig_pkg;
   typedef enum logic [1:0] {
      TE_MODE_INT = 2'd0,
      TE_MODE_ONE = 2'd1,
      TE_MODE_TWO = 2'd2,
      TE_MODE_RSV = 2'd3
   } te_mode_e;

   typedef struct packed {
      logic hs;
      logic vs;
   } te_evt_t;
endpackage

// File: rtl/te_pulse_meter.sv
module te_pulse_meter #(
   parameter int SYNC_STAGES = 2,
   parameter int WIDTH_W     = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               pin,
   input  logic               pol,
   output logic               ended,
   output logic [WIDTH_W-1:0] width
);
   localparam logic [WIDTH_W-1:0] W_MAX = {WIDTH_W{1'b1}};

   logic [SYNC_STAGES-1:0] chain;
   logic                   act, act_d;

   // synchronizer depth picked by parameter
   generate
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= '0;
            else        chain <= pin;
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-2:0], pin};
      end
   endgenerate

   assign act = pol ? chain[SYNC_STAGES-1] : ~chain[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_d <= 1'b0;
         width <= '0;
      end else begin
         act_d <= act;
         if (!en || !act)       width <= '0;
         else if (width != W_MAX) width <= width + 1'b1;
      end
   end

   assign ended = en & act_d & ~act;
endmodule

// File: rtl/te_line_tracker.sv
module te_line_tracker
   import te_trig_pkg::*;
#(
   parameter int WIDTH_W = 8,
   parameter int LINE_W  = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  te_mode_e           mode,
   input  logic               a_end,
   input  logic [WIDTH_W-1:0] a_w,
   input  logic               b_end,
   input  logic [WIDTH_W-1:0] b_w,
   input  logic [WIDTH_W-1:0] hs_min,
   input  logic [WIDTH_W-1:0] vs_min,
   input  logic [LINE_W-1:0]  trig_line,
   output logic               hit
);
   localparam logic [LINE_W-1:0] L_MAX = {LINE_W{1'b1}};

   te_evt_t           evt;
   logic [LINE_W-1:0] line;
   logic              seen_vs;

   always_comb begin
      evt = '0;
      unique case (mode)
         TE_MODE_ONE: if (a_end) begin
            if (vs_min > hs_min) begin
               evt.vs = (a_w >= vs_min);
               evt.hs = !evt.vs && (a_w >= hs_min);
            end else begin
               evt.hs = (a_w >= hs_min);
               evt.vs = !evt.hs && (a_w >= vs_min);
            end
         end
         TE_MODE_TWO: begin
            evt.vs = b_end && (b_w >= vs_min);
            evt.hs = a_end && (a_w >= hs_min) && !evt.vs;
         end
         default: evt = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line    <= '0;
         seen_vs <= 1'b0;
      end else if (!en) begin
         line    <= '0;
         seen_vs <= 1'b0;
      end else if (evt.vs) begin
         line    <= '0;
         seen_vs <= 1'b1;
      end else if (evt.hs && seen_vs && line != L_MAX) begin
         line    <= line + 1'b1;
      end
   end

   assign hit = evt.hs && seen_vs && (line == trig_line);
endmodule

// File: rtl/te_pixel_counter.sv
module te_pixel_counter #(
   parameter int PIX_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             go,
   input  logic             adv,
   input  logic [PIX_W-1:0] total,
   output logic             busy,
   output logic             done
);
   logic [PIX_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else if (!en) begin
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            cnt  <= '0;
            busy <= 1'b1;
         end else if (busy) begin
            if (total == '0) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else if (adv) begin
               if (cnt + 1'b1 == total) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/te_xfer_trigger.sv
module te_xfer_trigger
   import te_trig_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int WIDTH_W     = 8,
   parameter int LINE_W      = 11,
   parameter int PIX_W       = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [1:0]         sync_mode,
   input  logic               start_req,
   input  logic               pol_a,
   input  logic               pol_b,
   input  logic [WIDTH_W-1:0] hs_min,
   input  logic [WIDTH_W-1:0] vs_min,
   input  logic [LINE_W-1:0]  trig_line,
   input  logic [PIX_W-1:0]   pix_total,
   input  logic               te_a,
   input  logic               te_b,
   input  logic               pix_advance,
   output logic               xfer_start,
   output logic               xfer_busy,
   output logic               xfer_done,
   output logic               start_pending
);
   localparam int NPIN = 2;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (WIDTH_W < 3) begin : g_bad_width
         $error("WIDTH_W must hold a width of at least 4");
      end
      if (LINE_W < 1 || PIX_W < 1) begin : g_bad_count
         $error("LINE_W and PIX_W must be positive");
      end
   endgenerate

   te_mode_e           mode;
   logic [NPIN-1:0]    pins, pols, ended;
   logic [WIDTH_W-1:0] widths [NPIN];
   logic               line_hit, go, used;

   assign mode = te_mode_e'(sync_mode);
   assign pins = {te_b, te_a};
   assign pols = {pol_b, pol_a};

   generate
      for (genvar p = 0; p < NPIN; p++) begin : g_meter
         te_pulse_meter #(
            .SYNC_STAGES(SYNC_STAGES),
            .WIDTH_W    (WIDTH_W)
         ) u_meter (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (enable),
            .pin  (pins[p]),
            .pol  (pols[p]),
            .ended(ended[p]),
            .width(widths[p])
         );
      end
   endgenerate

   te_line_tracker #(
      .WIDTH_W(WIDTH_W),
      .LINE_W (LINE_W)
   ) u_lines (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (enable),
      .mode     (mode),
      .a_end    (ended[0]),
      .a_w      (widths[0]),
      .b_end    (ended[1]),
      .b_w      (widths[1]),
      .hs_min   (hs_min),
      .vs_min   (vs_min),
      .trig_line(trig_line),
      .hit      (line_hit)
   );

   assign go = enable && !used && !xfer_busy &&
               ((mode == TE_MODE_INT) ? start_pending : line_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_pending <= 1'b0;
         used          <= 1'b0;
         xfer_start    <= 1'b0;
      end else begin
         xfer_start <= go;
         if (!enable) begin
            start_pending <= 1'b0;
            used          <= 1'b0;
         end else begin
            if (go) used <= 1'b1;
            if (go)
               start_pending <= 1'b0;
            else if (start_req && mode == TE_MODE_INT && !used)
               start_pending <= 1'b1;
         end
      end
   end

   te_pixel_counter #(
      .PIX_W(PIX_W)
   ) u_pix (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (enable),
      .go   (go),
      .adv  (pix_advance),
      .total(pix_total),
      .busy (xfer_busy),
      .done (xfer_done)
   );
endmodule

// File: rtl/te_xfer_trigger_chk.sv
module te_xfer_trigger_chk #(
   parameter int PIX_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic [1:0]       sync_mode,
   input logic [PIX_W-1:0] pix_total,
   input logic             pix_advance,
   input logic             xfer_start,
   input logic             xfer_busy,
   input logic             xfer_done,
   input logic             start_pending
);
   logic [PIX_W-1:0] seen;
   logic [1:0]       starts;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen   <= '0;
         starts <= '0;
      end else begin
         if (!xfer_busy)       seen <= '0;
         else if (pix_advance) seen <= seen + 1'b1;
         if (!enable)                        starts <= '0;
         else if (xfer_start && starts != 2'd3) starts <= starts + 1'b1;
      end
   end

   always_ff @(posedge clk)
      if (!rst_n)
         AST_RESET_QUIET: assert (!xfer_start && !xfer_busy && !xfer_done && !start_pending); // R1

   AST_PENDING_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> !start_pending);                                        // R2
   AST_PENDING_INT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_pending) |-> $past(sync_mode) == 2'd0);                    // R10
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> xfer_busy);                                             // R7
   AST_DONE_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> !xfer_busy && $past(xfer_busy));                         // R7
   AST_PIX_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> $past(seen) + ($past(pix_advance) ? 1 : 0) == pix_total || pix_total == '0); // R7
   AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> starts == 2'd0);                                        // R8
   AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !xfer_busy && !start_pending && !xfer_done);               // R9
endmodule

bind te_xfer_trigger te_xfer_trigger_chk #(.PIX_W(PIX_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .enable       (enable),
   .sync_mode    (sync_mode),
   .pix_total    (pix_total),
   .pix_advance  (pix_advance),
   .xfer_start   (xfer_start),
   .xfer_busy    (xfer_busy),
   .xfer_done    (xfer_done),
   .start_pending(start_pending)
);

// File: tb/te_xfer_trigger_bench.sv
`timescale 1ns/1ps
module te_xfer_trigger_bench;
   localparam int WIDTH_W = 8;
   localparam int LINE_W  = 11;
   localparam int PIX_W   = 16;
   localparam int GAP     = 12;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               enable = 1'b0;
   logic [1:0]         sync_mode = 2'd0;
   logic               start_req = 1'b0;
   logic               pol_a = 1'b1, pol_b = 1'b1;
   logic [WIDTH_W-1:0] hs_min = 8'd2, vs_min = 8'd4;
   logic [LINE_W-1:0]  trig_line = '0;
   logic [PIX_W-1:0]   pix_total = 16'd1;
   logic               te_a = 1'b0, te_b = 1'b0;
   logic               pix_advance = 1'b0;
   logic               xfer_start, xfer_busy, xfer_done, start_pending;

   int n_checks = 0, n_fail = 0;
   int adv_mode = 0;
   int hs_sent = 0;
   logic mon_clr = 1'b0;
   int n_start, n_done, n_busy, n_adv, start_hs;
   bit finished = 0;

   always #10 clk = ~clk;

   te_xfer_trigger #(.WIDTH_W(WIDTH_W), .LINE_W(LINE_W), .PIX_W(PIX_W)) u_te_xfer_trigger (
      .clk(clk), .rst_n(rst_n), .enable(enable), .sync_mode(sync_mode),
      .start_req(start_req), .pol_a(pol_a), .pol_b(pol_b),
      .hs_min(hs_min), .vs_min(vs_min), .trig_line(trig_line),
      .pix_total(pix_total), .te_a(te_a), .te_b(te_b),
      .pix_advance(pix_advance), .xfer_start(xfer_start),
      .xfer_busy(xfer_busy), .xfer_done(xfer_done),
      .start_pending(start_pending)
   );

   always @(posedge clk) begin
      #1;
      case (adv_mode)
         1:       pix_advance <= 1'b1;
         2:       pix_advance <= ~pix_advance;
         default: pix_advance <= 1'b0;
      endcase
   end

   always @(negedge clk) begin
      if (mon_clr) begin
         n_start = 0; n_done = 0; n_busy = 0; n_adv = 0; start_hs = -1;
      end else if (rst_n) begin
         if (xfer_start) begin n_start++; start_hs = hs_sent; end
         if (xfer_done) n_done++;
         if (xfer_busy) n_busy++;
         if (xfer_busy && pix_advance) n_adv++;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic open_session(input int mode, input int hs, input int vs, input int line,
                               input int total, input bit pa, input bit pb, input int am);
      sync_mode = mode[1:0]; hs_min = hs[WIDTH_W-1:0]; vs_min = vs[WIDTH_W-1:0];
      trig_line = line[LINE_W-1:0]; pix_total = total[PIX_W-1:0];
      pol_a = pa; pol_b = pb; te_a = ~pa; te_b = ~pb; adv_mode = am;
      hs_sent = 0;
      cyc(5);
      mon_clr = 1'b1;
      cyc(1);
      mon_clr = 1'b0;
      enable = 1'b1;
      cyc(1);
   endtask

   task automatic close_session();
      enable = 1'b0; adv_mode = 0;
      cyc(4);
   endtask

   // kind: 0 stray pulse, 1 line sync, 2 frame sync
   task automatic pulse(input bit on_b, input int w, input int kind);
      if (on_b) te_b = pol_b; else te_a = pol_a;
      cyc(w);
      if (on_b) te_b = ~pol_b; else te_a = ~pol_a;
      if (kind == 1) hs_sent++;
      if (kind == 2) hs_sent = 0;
      cyc(GAP);
   endtask

   task automatic t_reset();
      cyc(1);
      @(negedge clk);
      chk(!xfer_start && !xfer_busy && !xfer_done && !start_pending, "R1 reset outputs",
          {xfer_start, xfer_busy, xfer_done, start_pending}, 0);
      rst_n = 1'b1;
      cyc(2);
   endtask

   task automatic t_internal();
      open_session(0, 2, 4, 0, 5, 1, 1, 1);
      start_req = 1'b1;
      cyc(1);
      chk(start_pending == 1'b1, "R2 pending set", start_pending, 1);
      start_req = 1'b0;
      cyc(20);
      chk(n_start == 1, "R2 one start", n_start, 1);
      chk(start_pending == 1'b0, "R2 pending cleared", start_pending, 0);
      chk(n_busy == 5, "R7 busy cycles", n_busy, 5);
      chk(n_done == 1 && !xfer_busy, "R7 done once", n_done, 1);
      start_req = 1'b1;
      cyc(1);
      start_req = 1'b0;
      cyc(10);
      chk(n_start == 1, "R8 second request ignored", n_start, 1);
      close_session();
   endtask

   task automatic t_pix_gapped();
      open_session(0, 2, 4, 0, 4, 1, 1, 2);
      start_req = 1'b1;
      cyc(1);
      start_req = 1'b0;
      cyc(20);
      chk(n_adv == 4, "R7 gapped pixel count", n_adv, 4);
      chk(n_done == 1, "R7 gapped done", n_done, 1);
      close_session();
   endtask

   task automatic t_onepin();
      open_session(1, 3, 8, 2, 2, 1, 1, 1);
      pulse(1'b0, 3, 1);
      pulse(1'b1, 10, 0);
      chk(n_start == 0, "R6 no start before frame sync", n_start, 0);
      pulse(1'b0, 8, 2);
      pulse(1'b0, 3, 1);
      pulse(1'b0, 4, 1);
      chk(n_start == 0, "R6 early lines no start", n_start, 0);
      pulse(1'b0, 3, 1);
      chk(n_start == 1, "R4 one-pin start", n_start, 1);
      chk(start_hs == 3, "R6 start on line sync 3", start_hs, 3);
      chk(n_done == 1, "R7 done after one-pin start", n_done, 1);
      close_session();
   endtask

   task automatic t_onepin_glitch();
      open_session(1, 3, 6, 0, 1, 1, 1, 1);
      pulse(1'b0, 6, 2);
      pulse(1'b0, 2, 0);
      chk(n_start == 0, "R4 short pulse ignored", n_start, 0);
      pulse(1'b0, 4, 1);
      chk(n_start == 1 && start_hs == 1, "R4 mid width is line sync", n_start, 1);
      close_session();
      // frame sync threshold below line sync threshold
      open_session(1, 7, 4, 1, 1, 1, 1, 1);
      pulse(1'b0, 5, 2);
      pulse(1'b0, 3, 0);
      pulse(1'b0, 8, 1);
      chk(n_start == 0, "R4 swapped thresholds line 0", n_start, 0);
      pulse(1'b0, 5, 2);
      pulse(1'b0, 8, 1);
      pulse(1'b0, 7, 1);
      chk(n_start == 1 && start_hs == 2, "R4 swapped thresholds start", start_hs, 2);
      close_session();
   endtask

   task automatic t_twopin_low();
      open_session(2, 2, 2, 1, 1, 0, 0, 1);
      pulse(1'b1, 3, 2);
      pulse(1'b0, 1, 0);
      pulse(1'b0, 2, 1);
      chk(n_start == 0, "R5 short line pulse ignored", n_start, 0);
      pulse(1'b0, 2, 1);
      chk(n_start == 1 && start_hs == 2, "R3 active-low two-pin start", start_hs, 2);
      pulse(1'b1, 3, 2);
      pulse(1'b0, 2, 1);
      pulse(1'b0, 2, 1);
      chk(n_start == 1, "R8 one start per session", n_start, 1);
      close_session();
      open_session(2, 2, 5, 0, 1, 1, 1, 1);
      pulse(1'b1, 4, 0);
      pulse(1'b0, 2, 1);
      chk(n_start == 0, "R5 short frame pulse ignored", n_start, 0);
      pulse(1'b1, 5, 2);
      pulse(1'b0, 2, 1);
      chk(n_start == 1 && start_hs == 1, "R8 new session re-armed", n_start, 1);
      close_session();
   endtask

   task automatic t_abort();
      open_session(0, 2, 4, 0, 50, 1, 1, 1);
      start_req = 1'b1;
      cyc(1);
      start_req = 1'b0;
      cyc(6);
      enable = 1'b0;
      cyc(3);
      chk(!xfer_busy && !start_pending, "R9 abort clears busy", xfer_busy, 0);
      cyc(60);
      chk(n_done == 0, "R9 no done after abort", n_done, 0);
      close_session();
   endtask

   task automatic t_req_ignored();
      open_session(1, 3, 8, 0, 1, 1, 1, 1);
      start_req = 1'b1;
      cyc(1);
      start_req = 1'b0;
      chk(start_pending == 1'b0, "R10 request ignored in sync mode", start_pending, 0);
      cyc(10);
      chk(n_start == 0, "R10 no start from request", n_start, 0);
      close_session();
   endtask

   initial begin
      t_reset();
      t_internal();
      t_pix_gapped();
      t_onepin();
      t_onepin_glitch();
      t_twopin_low();
      t_abort();
      t_req_ignored();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end
endmodule